// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Store

This block behaves as the slave side of a serial EEPROM with 16-bit words, driven over a three-wire clocked serial link that is framed by a chip select. The bus master raises chip select and shifts in a command on the serial clock. A command is a start bit, a two-bit opcode, an address field and, for the write commands, one data word. The block decodes all seven commands: read, single-word write, single-word erase, whole-array erase, whole-array write, program unlock and program lock. For a read, the block shifts the addressed word back on its data-out line.

All storage is an on-chip register array. It holds 2^ADDR_W words, which is 64 words for a 6-bit address and 256 words for an 8-bit address. The serial inputs are asynchronous to the system clock, so the block brings them into that domain through synchronizer flops. It acts on each rising edge of the serial clock that it detects. A program operation finishes in the system-clock cycle after its last bit, so the model has no busy period. Every program command is gated by an unlock latch, which is cleared at reset.

Top module: `uwire_eeprom`

## Requirements
- R1: While chip select is high and no frame is in progress, the block ignores sampled data-in zeros. A frame begins on the first data-in 1 sampled on a rising serial-clock edge.
- R2: The start bit is followed by a 2-bit opcode, first bit first, and then an ADDR_W-bit address, MSB first. The opcodes are 10 = read, 01 = write and 11 = erase. Opcode 00 is an extended command: the two top address bits select it (11 = unlock, 10 = erase all, 01 = write all, 00 = lock) and the remaining address bits are don't-care.
- R3: For a read, after the last address bit, data-out shows one 0 bit. Each following rising serial-clock edge then launches the next bit of the addressed word, D15 first.
- R4: A write takes 16 data bits, D15 first, after the address. When the unlock latch is set, the word is stored once the 16th data bit has been sampled.
- R5: An erase sets the addressed word to 0xFFFF when the unlock latch is set.
- R6: Erase-all sets every word to 0xFFFF. Write-all takes 16 data bits and stores them in every word. Both act only when the unlock latch is set.
- R7: Reset clears the unlock latch. While the latch is clear, write, erase, write-all and erase-all leave every word unchanged.
- R8: The unlock command sets the latch and the lock command clears it, whatever the don't-care address bits hold.
- R9: Dropping chip select abandons a partial frame, and no program operation from that frame takes place. The next frame is decoded from its start bit.
- R10: Data-out is 0 whenever chip select is low and at every point outside the data phase of a read.
- R11: After reset every word reads 0xFFFF and data-out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the master, asynchronous |
| ser_sel | input | 1 | Chip select, active high, asynchronous |
| ser_din | input | 1 | Serial data from the master |
| ser_dout | output | 1 | Serial data to the master, 0 when idle |

## Verification
The hardest case to reach from the ports is a program command that arrives correctly formed at a moment when it must have no effect. This covers commands sent while the unlock latch is clear and write frames cut off partway through their data bits. In either case the only visible result is that nothing changes. The stimulus reaches these cases by writing known values first and then sending locked or truncated frames. It then reads the same addresses back and compares them with a bench model that applies only the commands that completed while unlocked. Random sequences of all seven commands, with the don't-care address bits randomised, run the latch through many lock and unlock cycles between reads.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILLW  = 2'b01;
    localparam logic [1:0] SUB_WIPE   = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_OUT,
        ST_HOLD
    } fst_t;

    typedef struct packed {
        logic wr_one;
        logic wr_all;
        logic er_one;
        logic er_all;
    } prog_t;

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/uwire_sync.sv
module uwire_sync (
    input  logic clk,
    input  logic rst,
    input  logic sk,
    input  logic cs,
    input  logic di,
    output logic sk_rise,
    output logic cs_s,
    output logic di_s
);
    logic [2:0] sk_q;
    logic [1:0] cs_q;
    logic [1:0] di_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_q <= '0;
            cs_q <= '0;
            di_q <= '0;
        end else begin
            sk_q <= {sk_q[1:0], sk};
            cs_q <= {cs_q[0], cs};
            di_q <= {di_q[0], di};
        end
    end

    assign sk_rise = sk_q[1] & ~sk_q[2];
    assign cs_s    = cs_q[1];
    assign di_s    = di_q[1];

endmodule

// File: rtl/uwire_frame.sv
module uwire_frame
    import uwire_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sk_rise,
    input  logic              cs_s,
    input  logic              di_s,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] pg_addr,
    output logic [WORD_W-1:0] pg_data,
    output prog_t             pg_cmd,
    output logic              pg_en,
    output logic              do_bit
);
    localparam int MAXB  = max_of(ADDR_W, WORD_W);
    localparam int CNT_W = $clog2(MAXB + 1);
    localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(WORD_W - 1);

    fst_t              st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        opc_q;
    logic [ADDR_W-1:0] adr_q;
    logic [WORD_W-1:0] dat_q;
    logic [WORD_W:0]   out_q;
    logic              en_q;
    prog_t             cmd_q;
    logic [ADDR_W-1:0] adr_nxt;
    logic [WORD_W-1:0] dat_nxt;
    logic [1:0]        sub_nxt;

    assign adr_nxt = {adr_q[ADDR_W-2:0], di_s};
    assign dat_nxt = {dat_q[WORD_W-2:0], di_s};
    assign sub_nxt = adr_nxt[ADDR_W-1 -: 2];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            opc_q <= '0;
            adr_q <= '0;
            dat_q <= '0;
            out_q <= '0;
            en_q  <= 1'b0;
            cmd_q <= '0;
        end else begin
            cmd_q <= '0;
            if (!cs_s) begin
                st_q  <= ST_IDLE;
                cnt_q <= '0;
                out_q <= '0;
            end else if (sk_rise) begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (di_s) begin
                            st_q  <= ST_OPC;
                            cnt_q <= '0;
                        end
                    end
                    ST_OPC: begin
                        opc_q <= {opc_q[0], di_s};
                        if (cnt_q == CNT_W'(1)) begin
                            st_q  <= ST_ADR;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_ADR: begin
                        adr_q <= adr_nxt;
                        if (cnt_q == ADR_LAST) begin
                            cnt_q <= '0;
                            st_q  <= ST_HOLD;
                            unique case (opc_q)
                                OPC_READ: begin
                                    out_q <= {1'b0, rd_word};
                                    st_q  <= ST_OUT;
                                end
                                OPC_WRITE: st_q <= ST_DAT;
                                OPC_ERASE: cmd_q.er_one <= 1'b1;
                                default: begin
                                    unique case (sub_nxt)
                                        SUB_UNLOCK: en_q <= 1'b1;
                                        SUB_LOCK:   en_q <= 1'b0;
                                        SUB_WIPE:   cmd_q.er_all <= 1'b1;
                                        default:    st_q <= ST_DAT;
                                    endcase
                                end
                            endcase
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DAT: begin
                        dat_q <= dat_nxt;
                        if (cnt_q == DAT_LAST) begin
                            cnt_q <= '0;
                            st_q  <= ST_HOLD;
                            if (opc_q == OPC_WRITE) cmd_q.wr_one <= 1'b1;
                            else                    cmd_q.wr_all <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_OUT:  out_q <= {out_q[WORD_W-1:0], 1'b0};
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr = adr_nxt;
    assign pg_addr = adr_q;
    assign pg_data = dat_q;
    assign pg_cmd  = cmd_q;
    assign pg_en   = en_q;
    assign do_bit  = (st_q == ST_OUT) ? out_q[WORD_W] : 1'b0;

    // R3
    dummy_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_OUT) |-> !do_bit);

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> (st_q == ST_IDLE));

    // R7
    lock_reset_chk: assert property (@(posedge clk)
        rst |=> !en_q);

endmodule

// File: rtl/uwire_store.sv
module uwire_store
    import uwire_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  prog_t             cmd,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                mem[i] <= '1;
            end else if (en) begin
                if (cmd.er_all || (cmd.er_one && addr == ADDR_W'(i)))
                    mem[i] <= '1;
                else if (cmd.wr_all || (cmd.wr_one && addr == ADDR_W'(i)))
                    mem[i] <= wdata;
            end
        end
    end

    assign rd_word = mem[rd_addr];

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == '0) |=> $stable(mem[0]));

    // R5
    erase_one_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cmd.er_one) |=> (mem[$past(addr)] == '1));

endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
    import uwire_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_sel,
    input  logic ser_din,
    output logic ser_dout
);
    logic              sk_rise;
    logic              cs_s;
    logic              di_s;
    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] pg_addr;
    logic [WORD_W-1:0] pg_data;
    prog_t             pg_cmd;
    logic              pg_en;
    logic              do_bit;

    uwire_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .sk      (ser_clk),
        .cs      (ser_sel),
        .di      (ser_din),
        .sk_rise (sk_rise),
        .cs_s    (cs_s),
        .di_s    (di_s)
    );

    uwire_frame #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .sk_rise (sk_rise),
        .cs_s    (cs_s),
        .di_s    (di_s),
        .rd_word (rd_word),
        .rd_addr (rd_addr),
        .pg_addr (pg_addr),
        .pg_data (pg_data),
        .pg_cmd  (pg_cmd),
        .pg_en   (pg_en),
        .do_bit  (do_bit)
    );

    uwire_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cmd     (pg_cmd),
        .en      (pg_en),
        .addr    (pg_addr),
        .wdata   (pg_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    assign ser_dout = cs_s & do_bit;

    // R10
    quiet_dout_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_s |-> !ser_dout);

endmodule

// File: tb/uwire_eeprom_test.sv
module uwire_eeprom_test;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_sel = 1'b0;
    logic ser_din = 1'b0;
    logic ser_dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] model_mem [DEPTH];
    bit          model_en;

    always #4 clk = ~clk;

    uwire_eeprom #(.ADDR_W(AW), .WORD_W(16)) uut (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_sel  (ser_sel),
        .ser_din  (ser_din),
        .ser_dout (ser_dout)
    );

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(bit b);
        ser_din = b;
        wait_n(4);
        ser_clk = 1'b1;
        wait_n(4);
        ser_clk = 1'b0;
    endtask

    task automatic open_frame(int zeros);
        ser_sel = 1'b1;
        ser_din = 1'b0;
        wait_n(4);
        for (int i = 0; i < zeros; i++) send_bit(1'b0);
    endtask

    task automatic close_frame();
        ser_sel = 1'b0;
        ser_din = 1'b0;
        wait_n(6);
    endtask

    task automatic send_head(logic [1:0] opc, logic [AW-1:0] adr);
        send_bit(1'b1);
        send_bit(opc[1]);
        send_bit(opc[0]);
        for (int i = AW - 1; i >= 0; i--) send_bit(adr[i]);
    endtask

    task automatic send_word(logic [15:0] w, int nbits);
        for (int i = 15; i >= 16 - nbits; i--) send_bit(w[i]);
    endtask

    function automatic logic [15:0] model_read(logic [AW-1:0] a);
        return model_mem[a];
    endfunction

    task automatic read_word(logic [AW-1:0] a, int zeros, output logic [15:0] w, output logic dummy);
        open_frame(zeros);
        send_head(2'b10, a);
        dummy = ser_dout;
        w = '0;
        for (int i = 0; i < 16; i++) begin
            send_bit(1'b0);
            w = {w[14:0], ser_dout};
        end
        close_frame();
    endtask

    task automatic check_read(logic [AW-1:0] a, string tag);
        logic [15:0] w;
        logic d;
        read_word(a, 0, w, d);
        check(d == 1'b0, {tag, " dummy"}, {15'd0, d}, 16'h0000);
        check(w == model_read(a), tag, w, model_read(a));
        check(ser_dout == 1'b0, "R10 idle dout", {15'd0, ser_dout}, 16'h0000);
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [15:0] w);
        open_frame(0);
        send_head(2'b01, a);
        send_word(w, 16);
        close_frame();
        if (model_en) model_mem[a] = w;
    endtask

    task automatic do_erase(logic [AW-1:0] a);
        open_frame(0);
        send_head(2'b11, a);
        close_frame();
        if (model_en) model_mem[a] = 16'hFFFF;
    endtask

    task automatic do_ext(logic [1:0] sub, logic [15:0] w);
        logic [AW-1:0] a;
        a = AW'($urandom);
        a[AW-1 -: 2] = sub;
        open_frame(0);
        send_head(2'b00, a);
        if (sub == 2'b01) send_word(w, 16);
        close_frame();
        case (sub)
            2'b11: model_en = 1'b1;
            2'b00: model_en = 1'b0;
            2'b10: if (model_en) for (int i = 0; i < DEPTH; i++) model_mem[i] = 16'hFFFF;
            default: if (model_en) for (int i = 0; i < DEPTH; i++) model_mem[i] = w;
        endcase
    endtask

    initial begin
        wait_n(400000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic d;
        int unsigned seed;
        seed = $urandom(32'd31337);
        for (int i = 0; i < DEPTH; i++) model_mem[i] = 16'hFFFF;
        model_en = 1'b0;
        wait_n(5);
        rst = 1'b0;
        wait_n(3);

        // R11 reset state
        check(ser_dout == 1'b0, "R11 dout after reset", {15'd0, ser_dout}, 16'h0000);
        check_read(6'd0, "R11 word 0 erased");
        check_read(6'd63, "R11 top word erased");

        // R7 programming while locked has no effect
        do_write(6'd3, 16'h1234);
        check_read(6'd3, "R7 locked write");
        do_ext(2'b01, 16'h0F0F);
        check_read(6'd9, "R7 locked write-all");

        // R8 unlock, R4 write, R2 address order
        do_ext(2'b11, 16'h0);
        do_write(6'd3, 16'h1234);
        do_write(6'd32, 16'hA5C3);
        do_write(6'd1, 16'h8001);
        check_read(6'd3, "R4 write word 3");
        check_read(6'd32, "R2 MSB-first address 32");
        check_read(6'd1, "R2 LSB address 1");

        // R1 leading zeros before start bit
        read_word(6'd3, 3, w, d);
        check(w == 16'h1234, "R1 leading zeros", w, 16'h1234);

        // R9 aborted write keeps old word
        open_frame(0);
        send_head(2'b01, 6'd3);
        send_word(16'h0000, 8);
        close_frame();
        check_read(6'd3, "R9 aborted write");

        // R10 abort in the middle of a read
        open_frame(0);
        send_head(2'b10, 6'd32);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        ser_sel = 1'b0;
        wait_n(5);
        check(ser_dout == 1'b0, "R10 dout after read abort", {15'd0, ser_dout}, 16'h0000);
        wait_n(2);

        // R5 erase
        do_erase(6'd32);
        check_read(6'd32, "R5 erase word 32");

        // R8 lock then erase has no effect
        do_ext(2'b00, 16'h0);
        do_erase(6'd3);
        check_read(6'd3, "R8 locked erase");

        // R6 write-all then erase-all
        do_ext(2'b11, 16'h0);
        do_ext(2'b01, 16'h3C5A);
        check_read(6'd0, "R6 write-all low");
        check_read(6'd63, "R6 write-all high");
        do_ext(2'b10, 16'h0);
        check_read(6'd17, "R6 erase-all");

        // random mix, R2 R3 R4 R5 R6 R8
        for (int n = 0; n < 150; n++) begin
            int unsigned r;
            logic [AW-1:0] a;
            r = $urandom_range(0, 99);
            a = AW'($urandom);
            if (r < 35)      check_read(a, "R3 random read");
            else if (r < 60) do_write(a, 16'($urandom));
            else if (r < 72) do_erase(a);
            else if (r < 80) do_ext(2'b11, 16'h0);
            else if (r < 88) do_ext(2'b00, 16'h0);
            else if (r < 92) do_ext(2'b10, 16'h0);
            else if (r < 96) do_ext(2'b01, 16'($urandom));
            else             check_read(a, "R2 random read");
        end
        for (int i = 0; i < DEPTH; i += 7) check_read(AW'(i), "R6 final scan");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule